// File: doc/BRIEF.md
# Speed-Dependent Forwarded Clock Generator

This block runs from one 125 MHz reference clock. It makes the clock signals that a serial gigabit media adapter needs at three line rates: 1 Gb/s, 100 Mb/s and 10 Mb/s. A 2-bit speed select picks the rate. The block drives a matched pair of pattern bits. The first is registered on the rising edge of the reference clock and the second on its falling edge. An external double-data-rate output register takes this pair and forwards a clock off chip at 125 MHz, 12.5 MHz or 1.25 MHz.

The third output is a one-cycle clock enable. It marks each falling edge of the forwarded clock, so downstream adaptation logic knows which reference cycles carry data.

At the divided rates a phase counter runs over one forwarded period: 10 reference cycles at 100 Mb/s and 100 at 10 Mb/s. The outputs are decoded from the counter's next value and registered, so every output comes straight from a flop. The counter starts again from phase zero when reset is released and whenever the speed select changes.

Top module: `fclk_gen`

## Requirements
- R1: While `rst_n` is low, `rise_o`, `fall_o` and `en_o` are all 0.
- R2: With `speed_sel` = 2'b10 (1 Gb/s), `rise_o` is 0, `fall_o` is 1 and `en_o` is 1 in every reference cycle.
- R3: With `speed_sel` = 2'b01 (100 Mb/s), `rise_o` has a period of 10 reference cycles. It is 1 for the 5 cycles at phases 0 to 4 and 0 for the 5 cycles at phases 5 to 9.
- R4: With `speed_sel` = 2'b00 (10 Mb/s), `rise_o` has a period of 100 reference cycles. It is 1 for phases 0 to 49 and 0 for phases 50 to 99.
- R5: At the divided rates, `en_o` is 1 only in the cycle at phase 5 or phase 50, where `rise_o` has just gone from 1 to 0. That gives exactly one enable cycle per forwarded period.
- R6: `fall_o` is updated on the falling reference edge. After that edge it equals the `rise_o` value of the same cycle at the divided rates, and it is 1 at 1 Gb/s.
- R7: The first cycle after reset release, and the first cycle after any change of `speed_sel`, is phase 0 (`rise_o`=1, `en_o`=0 at a divided rate). The first enable follows half a forwarded period later.
- R8: `speed_sel` = 2'b11 behaves exactly like 2'b10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | 125 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| speed_sel | input | 2 | 00 = 10 Mb/s, 01 = 100 Mb/s, 1x = 1 Gb/s |
| rise_o | output | 1 | Pattern bit for the rising-edge half of the DDR register |
| fall_o | output | 1 | Pattern bit for the falling-edge half, registered on the falling edge |
| en_o | output | 1 | One-cycle enable marking the forwarded clock's falling edge |

## Verification
On every clock the assertions check four things:
- the reset value of all outputs;
- the constant outputs at 1 Gb/s;
- that the two DDR pattern halves agree at the divided rates;
- that each enable follows a falling `rise_o`.

The exact period and duty of the divided pattern are left to the bench scenarios. So are the enable count over a window, the phase-zero restart after speed changes and after a reset in mid-period, and the equivalence of the two 1 Gb/s codes. The bench checks these against a phase model computed from the requirements.

// File: rtl/fclk_pkg.sv
package fclk_pkg;

  typedef enum logic [1:0] {
    SPD_10M    = 2'b00,
    SPD_100M   = 2'b01,
    SPD_1G     = 2'b10,
    SPD_1G_ALT = 2'b11
  } fclk_speed_e;

  function automatic logic is_full_rate(input logic [1:0] sel);
    return sel[1];
  endfunction

endpackage

// File: rtl/fclk_speed_dec.sv
module fclk_speed_dec #(
  parameter int HALF_FAST = 5,
  parameter int HALF_SLOW = 50,
  parameter int CNT_W     = 7
) (
  input  logic [1:0]       speed_sel,
  output logic             full_o,
  output logic [CNT_W-1:0] half_o,
  output logic [CNT_W-1:0] last_o
);
  import fclk_pkg::*;

  localparam logic [CNT_W-1:0] HALF_F = CNT_W'(HALF_FAST);
  localparam logic [CNT_W-1:0] HALF_S = CNT_W'(HALF_SLOW);
  localparam logic [CNT_W-1:0] LAST_F = CNT_W'(2 * HALF_FAST - 1);
  localparam logic [CNT_W-1:0] LAST_S = CNT_W'(2 * HALF_SLOW - 1);

  always_comb begin
    full_o = is_full_rate(speed_sel);
    if (speed_sel == SPD_100M) begin
      half_o = HALF_F;
      last_o = LAST_F;
    end else begin
      half_o = HALF_S;
      last_o = LAST_S;
    end
  end

endmodule

// File: rtl/fclk_phase_ctr.sv
module fclk_phase_ctr #(
  parameter int CNT_W = 7
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic [1:0]       speed_sel,
  input  logic             full_i,
  input  logic [CNT_W-1:0] last_i,
  output logic [CNT_W-1:0] phase_nxt_o
);

  logic [CNT_W-1:0] phase_q;
  logic [1:0]       spd_q;
  logic             run_q;
  logic             restart;

  // Restart on the first active edge, on a speed change, and at full rate.
  always_comb begin
    restart = !run_q || (speed_sel != spd_q) || full_i;
    if (restart) begin
      phase_nxt_o = '0;
    end else if (phase_q == last_i) begin
      phase_nxt_o = '0;
    end else begin
      phase_nxt_o = phase_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      spd_q   <= '0;
      run_q   <= 1'b0;
    end else begin
      phase_q <= phase_nxt_o;
      spd_q   <= speed_sel;
      run_q   <= 1'b1;
    end
  end

endmodule

// File: rtl/fclk_pattern_reg.sv
module fclk_pattern_reg #(
  parameter int CNT_W = 7
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             full_i,
  input  logic [CNT_W-1:0] half_i,
  input  logic [CNT_W-1:0] phase_nxt_i,
  output logic             rise_o,
  output logic             fall_o,
  output logic             en_o
);

  logic rise_d, en_d;
  logic rise_q, en_q, full_q, fall_q;

  always_comb begin
    if (full_i) begin
      rise_d = 1'b0;
      en_d   = 1'b1;
    end else begin
      rise_d = (phase_nxt_i < half_i);
      en_d   = (phase_nxt_i == half_i);
    end
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= 1'b0;
      en_q   <= 1'b0;
      full_q <= 1'b0;
    end else begin
      rise_q <= rise_d;
      en_q   <= en_d;
      full_q <= full_i;
    end
  end

  // Falling-edge half: half a reference cycle behind the rising half.
  always_ff @(negedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      fall_q <= 1'b0;
    end else begin
      fall_q <= full_q | rise_q;
    end
  end

  assign rise_o = rise_q;
  assign fall_o = fall_q;
  assign en_o   = en_q;

endmodule

// File: rtl/fclk_gen.sv
module fclk_gen #(
  parameter int HALF_FAST = 5,
  parameter int HALF_SLOW = 50
) (
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic [1:0] speed_sel,
  output logic       rise_o,
  output logic       fall_o,
  output logic       en_o
);

  localparam int CNT_W = $clog2(2 * HALF_SLOW);

  logic             full;
  logic [CNT_W-1:0] half;
  logic [CNT_W-1:0] last;
  logic [CNT_W-1:0] phase_nxt;

  fclk_speed_dec #(
    .HALF_FAST (HALF_FAST),
    .HALF_SLOW (HALF_SLOW),
    .CNT_W     (CNT_W)
  ) dec_i (
    .speed_sel (speed_sel),
    .full_o    (full),
    .half_o    (half),
    .last_o    (last)
  );

  fclk_phase_ctr #(
    .CNT_W (CNT_W)
  ) ctr_i (
    .clk_ref     (clk_ref),
    .rst_n       (rst_n),
    .speed_sel   (speed_sel),
    .full_i      (full),
    .last_i      (last),
    .phase_nxt_o (phase_nxt)
  );

  fclk_pattern_reg #(
    .CNT_W (CNT_W)
  ) pat_i (
    .clk_ref     (clk_ref),
    .rst_n       (rst_n),
    .full_i      (full),
    .half_i      (half),
    .phase_nxt_i (phase_nxt),
    .rise_o      (rise_o),
    .fall_o      (fall_o),
    .en_o        (en_o)
  );

endmodule

// File: rtl/fclk_gen_chk.sv
module fclk_gen_chk (
  input logic       clk_ref,
  input logic       rst_n,
  input logic [1:0] speed_sel,
  input logic       rise_o,
  input logic       fall_o,
  input logic       en_o
);

  // Counts active edges since reset release, saturating at 2.
  logic [1:0] age_q;
  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= 2'd0;
    end else if (age_q != 2'd2) begin
      age_q <= age_q + 2'd1;
    end
  end

  AST_RESET_LOW: assert property (@(posedge clk_ref)
    !rst_n |-> (!rise_o && !fall_o && !en_o)); // R1

  AST_FULL_CONST: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (age_q != 2'd0) && $past(speed_sel[1]) |-> (en_o && !rise_o && fall_o)); // R2

  AST_HALVES_MATCH: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (age_q != 2'd0) && !$past(speed_sel[1]) |-> (fall_o == rise_o)); // R6

  AST_EN_AT_FALL: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (age_q == 2'd2) && !$past(speed_sel[1]) && en_o |-> (!rise_o && $past(rise_o))); // R5

endmodule

bind fclk_gen fclk_gen_chk chk_i (
  .clk_ref   (clk_ref),
  .rst_n     (rst_n),
  .speed_sel (speed_sel),
  .rise_o    (rise_o),
  .fall_o    (fall_o),
  .en_o      (en_o)
);

// File: tb/fclk_gen_tb_top.sv
module fclk_gen_tb_top;

  localparam int CLK_PERIOD = 8;
  localparam int H_FAST     = 5;
  localparam int H_SLOW     = 50;

  logic       clk_ref = 1'b0;
  logic       rst_n;
  logic [1:0] speed_sel;
  logic       rise_o, fall_o, en_o;

  int n_run  = 0;
  int n_fail = 0;

  // Reference model state
  int   m_phase   = 0;
  bit   m_run     = 0;
  logic [1:0] m_prev = 2'b00;
  bit   m_restart = 0;
  int   en_count  = 0;

  always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

  fclk_gen #(.HALF_FAST(H_FAST), .HALF_SLOW(H_SLOW)) dut_i (
    .clk_ref   (clk_ref),
    .rst_n     (rst_n),
    .speed_sel (speed_sel),
    .rise_o    (rise_o),
    .fall_o    (fall_o),
    .en_o      (en_o)
  );

  task automatic check1(input string req, input string what,
                        input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // One reference cycle: update the model at the edge, compare after the falling edge.
  task automatic cycle();
    logic e_rise, e_fall, e_en;
    string tag;
    bit full;
    int h;
    @(posedge clk_ref);
    full = speed_sel[1];
    h    = (speed_sel == 2'b01) ? H_FAST : H_SLOW;
    if (!rst_n) begin
      m_run = 0;
      e_rise = 0; e_fall = 0; e_en = 0;
      tag = "R1";
    end else begin
      m_restart = !m_run || (speed_sel != m_prev) || full;
      if (m_restart) m_phase = 0;
      else m_phase = (m_phase + 1) % (2 * h);
      m_run = 1;
      e_rise = !full && (m_phase < h);
      e_fall = full ? 1'b1 : e_rise;
      e_en   = full ? 1'b1 : (m_phase == h);
      if (full) tag = (speed_sel == 2'b11) ? "R8" : "R2";
      else if (m_restart) tag = "R7";
      else tag = (speed_sel == 2'b01) ? "R3" : "R4";
    end
    m_prev = speed_sel;
    #(CLK_PERIOD * 3 / 4);
    check1(tag, "rise_o", rise_o, e_rise);
    check1((rst_n && !full) ? "R6" : tag, "fall_o", fall_o, e_fall);
    check1((rst_n && !full && !m_restart) ? "R5" : tag, "en_o", en_o, e_en);
    if (en_o) en_count++;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired (all requirements)");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    speed_sel = 2'b01;
    run(3);                                   // R1 reset state
    rst_n = 1'b1;
    run(120);                                 // R3, R5, R6, R7 at 100 Mb/s

    speed_sel = 2'b00;                        // R7 restart, R4 pattern
    en_count = 0;
    run(300);
    check1("R5", "enable count over 300 cycles at 10 Mb/s",
           logic'(en_count == 3), 1'b1);

    speed_sel = 2'b01;
    en_count = 0;
    run(H_FAST);
    check1("R7", "no enable before half period after restart",
           logic'(en_count == 0), 1'b1);
    run(1);
    check1("R7", "first enable at half period after restart",
           logic'(en_count == 1), 1'b1);

    speed_sel = 2'b10; run(20);               // R2
    speed_sel = 2'b11; run(20);               // R8
    speed_sel = 2'b01; run(3);
    speed_sel = 2'b00; run(130);              // mid-period change, R7/R4
    speed_sel = 2'b01; run(7);
    speed_sel = 2'b11; run(5);
    speed_sel = 2'b00; run(73);

    rst_n = 1'b0; run(2);                     // R1 mid-run reset
    rst_n = 1'b1; run(160);                   // R7 after reset release

    for (int s = 0; s < 4; s++) begin         // sweep every code
      speed_sel = 2'(s);
      run(210);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule